// File: doc/BRIEF.md
# Exhaustive Spare Row/Column Repair Analyzer

This block sits beside an at-speed memory self-test engine for a word-oriented memory that carries a small number of spare rows and spare columns. On every cycle the self-test may present a failing read: a row address, a word column address and a mask of the failing bits in that word. The analyzer never holds up the test. It keeps no failure bitmap. It runs one lane for every distinct order in which the spares can be handed out. Each lane decides, as each uncovered failure arrives, whether to spend a spare row or a spare column on it.

All lanes see the same failure in the same cycle. A word with several failing bits is settled completely in that cycle. When the test signals completion, the block reports whether any lane covered every failure. If one did, it also reports the lowest-numbered such lane and the row and column addresses that lane allocated. These results drive the repair step that follows.

With the default parameters there are two spare rows, two spare columns and 8-bit words, which gives six lanes.

Top module: `spare_repair_analyzer`

## Requirements
- R1: After reset, `resultValid` and `repairable` are 0. A `startIn` pulse clears every lane and the reported result, so `resultValid` is 0 in the cycle after it.
- R2: Lane k follows the k-th pattern, in ascending numeric order, of all (rows+columns)-bit values that have exactly `SPARE_ROWS` ones. Bit i of the pattern gives allocation step i: 1 means row, 0 means column. With the defaults, lanes 0..5 follow RRCC, RCRC, CRRC, RCCR, CRCR and CCRR. The reported lane is the lowest-numbered lane that has not failed.
- R3: The physical column of failing bit b is `failCol*WORD_W + b`. A bit is covered when its row equals an allocated spare row or its physical column equals an allocated spare column. A covered bit consumes no spare.
- R4: When a lane's next step is a row, one spare row at `failRow` covers every remaining uncovered bit of that word.
- R5: When the next step is a column, the lane allocates a column for the lowest uncovered bit, then continues to the next uncovered bit with the following step. Spares fill slot 0 first, then slot 1.
- R6: A lane that needs a spare when none is left marks itself failed until the next start. After that, later failures leave it unchanged.
- R7: In the cycle after `testDone` is accepted, `resultValid` is 1 and stays 1 until the next start. `repairable` is 1 if any lane survived. For the chosen lane, `bestLane`, `repRow`/`repRowValid` and `repCol`/`repColValid` hold its allocations. When no lane survived, all of these are 0.
- R8: A failure presented in the same cycle as `testDone` is included in the result.
- R9: Failures are ignored before the first start, after the result is reported, and in a cycle where `startIn` is high.
- R10: A new failure is accepted on every cycle back to back, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startIn | input | 1 | Begin a new run; clears lanes and result |
| failValid | input | 1 | A failing read is presented this cycle |
| failRow | input | ROW_W | Row address of the failing word |
| failCol | input | COL_W | Word column address of the failing word |
| failMask | input | WORD_W | One bit per failing data bit |
| testDone | input | 1 | Self-test finished; report the result |
| resultValid | output | 1 | Result fields are valid |
| repairable | output | 1 | Some lane covered all failures |
| bestLane | output | LANE_W | Lowest surviving lane number |
| repRow | output | SPARE_ROWS*ROW_W | Allocated spare row addresses, slot 0 in low bits |
| repRowValid | output | SPARE_ROWS | Spare row slot in use |
| repCol | output | SPARE_COLS*PCOL_W | Allocated physical column addresses, slot 0 in low bits |
| repColValid | output | SPARE_COLS | Spare column slot in use |

## Verification
Two pairs of actions can fall in the same cycle. In the first, the last failure of a run arrives together with `testDone`. This is provoked with a four-failure diagonal pattern, which is repairable, and a fifth diagonal failure driven in the done cycle, which must turn the verdict into unrepairable. In the second, a failure arrives together with `startIn`. That is judged by confirming that the subsequent result shows no allocation. The same port-level readout also shows that failures arriving in the reported state and in the idle state leave the outputs untouched.

// File: rtl/spare_repair_pkg.sv
package spare_repair_pkg;

  typedef struct packed {
    logic clear;
    logic capture;
    logic latch;
  } strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } ctrl_state_t;

  function automatic int choose(input int n, input int k);
    int acc;
    acc = 1;
    for (int i = 0; i < k; i++) acc = acc * (n - i) / (i + 1);
    return acc;
  endfunction

  function automatic int popBits(input int v);
    int cnt;
    cnt = 0;
    for (int i = 0; i < 31; i++) if (((v >> i) & 1) == 1) cnt++;
    return cnt;
  endfunction

  // k-th value (ascending) with exactly nr ones in nr+nc bits; bit i = step i, 1 = row
  function automatic logic [31:0] nthOrder(input int idx, input int nr, input int nc);
    int seen;
    logic [31:0] found;
    seen  = 0;
    found = '0;
    for (int v = 0; v < (1 << (nr + nc)); v++) begin
      if (popBits(v) == nr) begin
        if (seen == idx) found = 32'(v);
        seen++;
      end
    end
    return found;
  endfunction

endpackage

// File: rtl/spare_repair_lane.sv
module spare_repair_lane
  import spare_repair_pkg::*;
#(
  parameter int ROW_W = 6,
  parameter int COL_W = 3,
  parameter int WORD_W = 8,
  parameter int SPARE_ROWS = 2,
  parameter int SPARE_COLS = 2,
  parameter logic [31:0] ORDER = 32'h3
) (
  input  logic clk,
  input  logic rst,
  input  strobe_t strb,
  input  logic [ROW_W-1:0] failRow,
  input  logic [COL_W-1:0] failCol,
  input  logic [WORD_W-1:0] failMask,
  output logic nxtFailed,
  output logic [SPARE_ROWS-1:0][ROW_W-1:0] nxtRow,
  output logic [SPARE_ROWS-1:0] nxtRowV,
  output logic [SPARE_COLS-1:0][COL_W+$clog2(WORD_W)-1:0] nxtCol,
  output logic [SPARE_COLS-1:0] nxtColV
);
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int PCOL_W = COL_W + BIT_W;
  localparam int TOTAL  = SPARE_ROWS + SPARE_COLS;
  localparam int STEP_W = $clog2(TOTAL + 1);
  localparam int RIDX_W = (SPARE_ROWS > 1) ? $clog2(SPARE_ROWS) : 1;
  localparam int CIDX_W = (SPARE_COLS > 1) ? $clog2(SPARE_COLS) : 1;

  logic failedQ;
  logic [SPARE_ROWS-1:0][ROW_W-1:0] rowQ;
  logic [SPARE_ROWS-1:0] rowVQ;
  logic [SPARE_COLS-1:0][PCOL_W-1:0] colQ;
  logic [SPARE_COLS-1:0] colVQ;

  logic [STEP_W-1:0] stepCnt;
  logic [RIDX_W-1:0] rowIdx;
  logic [CIDX_W-1:0] colIdx;
  logic [PCOL_W-1:0] physCol;
  logic covered;

  always_comb begin
    nxtFailed = failedQ;
    nxtRow    = rowQ;
    nxtRowV   = rowVQ;
    nxtCol    = colQ;
    nxtColV   = colVQ;
    stepCnt   = '0;
    rowIdx    = '0;
    colIdx    = '0;
    physCol   = '0;
    covered   = 1'b0;
    for (int r = 0; r < SPARE_ROWS; r++)
      if (rowVQ[r]) begin
        rowIdx  = rowIdx + 1'b1;
        stepCnt = stepCnt + 1'b1;
      end
    for (int c = 0; c < SPARE_COLS; c++)
      if (colVQ[c]) begin
        colIdx  = colIdx + 1'b1;
        stepCnt = stepCnt + 1'b1;
      end
    if (strb.capture && !failedQ) begin
      for (int b = 0; b < WORD_W; b++) begin
        physCol = {failCol, BIT_W'(b)};
        covered = 1'b0;
        for (int r = 0; r < SPARE_ROWS; r++)
          if (nxtRowV[r] && nxtRow[r] == failRow) covered = 1'b1;
        for (int c = 0; c < SPARE_COLS; c++)
          if (nxtColV[c] && nxtCol[c] == physCol) covered = 1'b1;
        if (failMask[b] && !covered && !nxtFailed) begin
          if (stepCnt == STEP_W'(TOTAL)) begin
            nxtFailed = 1'b1;
          end else if (ORDER[stepCnt]) begin
            nxtRow[rowIdx]  = failRow;
            nxtRowV[rowIdx] = 1'b1;
            rowIdx  = rowIdx + 1'b1;
            stepCnt = stepCnt + 1'b1;
          end else begin
            nxtCol[colIdx]  = physCol;
            nxtColV[colIdx] = 1'b1;
            colIdx  = colIdx + 1'b1;
            stepCnt = stepCnt + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strb.clear) begin
      failedQ <= 1'b0;
      rowQ    <= '0;
      rowVQ   <= '0;
      colQ    <= '0;
      colVQ   <= '0;
    end else begin
      failedQ <= nxtFailed;
      rowQ    <= nxtRow;
      rowVQ   <= nxtRowV;
      colQ    <= nxtCol;
      colVQ   <= nxtColV;
    end
  end

  assert_fail_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    failedQ && !strb.clear |=> failedQ);

  assert_frozen_after_fail_R6: assert property (@(posedge clk) disable iff (rst)
    failedQ && !strb.clear |=> $stable(rowQ) && $stable(colQ) && $stable(rowVQ) && $stable(colVQ));

  assert_clear_empties_R1: assert property (@(posedge clk) disable iff (rst)
    strb.clear |=> !failedQ && rowVQ == '0 && colVQ == '0);

  assert_idle_no_change_R9: assert property (@(posedge clk) disable iff (rst)
    !strb.capture && !strb.clear |=> $stable(rowVQ) && $stable(colVQ) && $stable(failedQ));

endmodule

// File: rtl/spare_repair_ctrl.sv
module spare_repair_ctrl
  import spare_repair_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic startIn,
  input  logic failValid,
  input  logic testDone,
  output strobe_t strb,
  output logic resultValid
);
  ctrl_state_t state;
  ctrl_state_t stateNext;

  always_comb begin
    strb.clear   = startIn;
    strb.capture = (state == ST_RUN) && failValid && !startIn;
    strb.latch   = (state == ST_RUN) && testDone && !startIn;
    stateNext    = state;
    if (startIn) stateNext = ST_RUN;
    else if (state == ST_RUN && testDone) stateNext = ST_DONE;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign resultValid = (state == ST_DONE);

  assert_done_holds_R7: assert property (@(posedge clk) disable iff (rst)
    resultValid && !startIn |=> resultValid);

  assert_done_follows_test_R8: assert property (@(posedge clk) disable iff (rst)
    state == ST_RUN && testDone && !startIn |=> resultValid);

  assert_start_drops_result_R1: assert property (@(posedge clk) disable iff (rst)
    startIn |=> !resultValid);

endmodule

// File: rtl/spare_repair_datapath.sv
module spare_repair_datapath
  import spare_repair_pkg::*;
#(
  parameter int ROW_W = 6,
  parameter int COL_W = 3,
  parameter int WORD_W = 8,
  parameter int SPARE_ROWS = 2,
  parameter int SPARE_COLS = 2,
  parameter int NUM_LANES = 6,
  parameter int LANE_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  strobe_t strb,
  input  logic [ROW_W-1:0] failRow,
  input  logic [COL_W-1:0] failCol,
  input  logic [WORD_W-1:0] failMask,
  output logic repairable,
  output logic [LANE_W-1:0] bestLane,
  output logic [SPARE_ROWS-1:0][ROW_W-1:0] repRow,
  output logic [SPARE_ROWS-1:0] repRowValid,
  output logic [SPARE_COLS-1:0][COL_W+$clog2(WORD_W)-1:0] repCol,
  output logic [SPARE_COLS-1:0] repColValid
);
  localparam int PCOL_W = COL_W + $clog2(WORD_W);

  logic [NUM_LANES-1:0] nxtFailed;
  logic [NUM_LANES-1:0][SPARE_ROWS-1:0][ROW_W-1:0] nxtRow;
  logic [NUM_LANES-1:0][SPARE_ROWS-1:0] nxtRowV;
  logic [NUM_LANES-1:0][SPARE_COLS-1:0][PCOL_W-1:0] nxtCol;
  logic [NUM_LANES-1:0][SPARE_COLS-1:0] nxtColV;

  for (genvar k = 0; k < NUM_LANES; k++) begin : gLane
    spare_repair_lane #(
      .ROW_W(ROW_W), .COL_W(COL_W), .WORD_W(WORD_W),
      .SPARE_ROWS(SPARE_ROWS), .SPARE_COLS(SPARE_COLS),
      .ORDER(nthOrder(k, SPARE_ROWS, SPARE_COLS))
    ) uLane (
      .clk(clk), .rst(rst), .strb(strb),
      .failRow(failRow), .failCol(failCol), .failMask(failMask),
      .nxtFailed(nxtFailed[k]), .nxtRow(nxtRow[k]), .nxtRowV(nxtRowV[k]),
      .nxtCol(nxtCol[k]), .nxtColV(nxtColV[k])
    );
  end

  logic [LANE_W-1:0] selLane;
  logic anyAlive;

  always_comb begin
    selLane  = '0;
    anyAlive = 1'b0;
    for (int k = NUM_LANES - 1; k >= 0; k--)
      if (!nxtFailed[k]) begin
        selLane  = LANE_W'(k);
        anyAlive = 1'b1;
      end
  end

  always_ff @(posedge clk) begin
    if (rst || strb.clear) begin
      repairable  <= 1'b0;
      bestLane    <= '0;
      repRow      <= '0;
      repRowValid <= '0;
      repCol      <= '0;
      repColValid <= '0;
    end else if (strb.latch) begin
      repairable  <= anyAlive;
      bestLane    <= selLane;
      repRow      <= anyAlive ? nxtRow[selLane]  : '0;
      repRowValid <= anyAlive ? nxtRowV[selLane] : '0;
      repCol      <= anyAlive ? nxtCol[selLane]  : '0;
      repColValid <= anyAlive ? nxtColV[selLane] : '0;
    end
  end

  assert_no_addr_when_unrepairable_R7: assert property (@(posedge clk) disable iff (rst)
    !repairable |-> repRowValid == '0 && repColValid == '0 && bestLane == '0);

  assert_verdict_tracks_lanes_R7: assert property (@(posedge clk) disable iff (rst)
    strb.latch && !strb.clear |=> repairable == $past(|(~nxtFailed)));

endmodule

// File: rtl/spare_repair_analyzer.sv
module spare_repair_analyzer
  import spare_repair_pkg::*;
#(
  parameter int ROW_W = 6,
  parameter int COL_W = 3,
  parameter int WORD_W = 8,
  parameter int SPARE_ROWS = 2,
  parameter int SPARE_COLS = 2,
  localparam int PCOL_W = COL_W + $clog2(WORD_W),
  localparam int NUM_LANES = choose(SPARE_ROWS + SPARE_COLS, SPARE_ROWS),
  localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic startIn,
  input  logic failValid,
  input  logic [ROW_W-1:0] failRow,
  input  logic [COL_W-1:0] failCol,
  input  logic [WORD_W-1:0] failMask,
  input  logic testDone,
  output logic resultValid,
  output logic repairable,
  output logic [LANE_W-1:0] bestLane,
  output logic [SPARE_ROWS-1:0][ROW_W-1:0] repRow,
  output logic [SPARE_ROWS-1:0] repRowValid,
  output logic [SPARE_COLS-1:0][PCOL_W-1:0] repCol,
  output logic [SPARE_COLS-1:0] repColValid
);
  strobe_t strb;

  spare_repair_ctrl uCtrl (
    .clk(clk), .rst(rst), .startIn(startIn), .failValid(failValid),
    .testDone(testDone), .strb(strb), .resultValid(resultValid)
  );

  spare_repair_datapath #(
    .ROW_W(ROW_W), .COL_W(COL_W), .WORD_W(WORD_W),
    .SPARE_ROWS(SPARE_ROWS), .SPARE_COLS(SPARE_COLS),
    .NUM_LANES(NUM_LANES), .LANE_W(LANE_W)
  ) uData (
    .clk(clk), .rst(rst), .strb(strb),
    .failRow(failRow), .failCol(failCol), .failMask(failMask),
    .repairable(repairable), .bestLane(bestLane),
    .repRow(repRow), .repRowValid(repRowValid),
    .repCol(repCol), .repColValid(repColValid)
  );

endmodule

// File: tb/spare_repair_analyzer_test.sv
`timescale 1ns/1ps
module spare_repair_analyzer_test;

  logic clk = 1'b0;
  logic rst;
  logic startIn, failValid, testDone;
  logic [5:0] failRow;
  logic [2:0] failCol;
  logic [7:0] failMask;
  logic resultValid, repairable;
  logic [2:0] bestLane;
  logic [1:0][5:0] repRow;
  logic [1:0] repRowValid;
  logic [1:0][5:0] repCol;
  logic [1:0] repColValid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  spare_repair_analyzer uut (
    .clk(clk), .rst(rst), .startIn(startIn), .failValid(failValid),
    .failRow(failRow), .failCol(failCol), .failMask(failMask),
    .testDone(testDone), .resultValid(resultValid), .repairable(repairable),
    .bestLane(bestLane), .repRow(repRow), .repRowValid(repRowValid),
    .repCol(repCol), .repColValid(repColValid)
  );

  typedef struct packed {
    logic [2:0] scen;
    logic       last;
    logic [5:0] row;
    logic [2:0] col;
    logic [7:0] mask;
  } fail_rec_t;

  typedef struct packed {
    logic       rep;
    logic [2:0] lane;
    logic [5:0] r0;
    logic [5:0] r1;
    logic [1:0] rv;
    logic [5:0] c0;
    logic [5:0] c1;
    logic [1:0] cv;
  } expect_t;

  // Failure records, driven back to back (R10); a scenario ends at last=1
  localparam fail_rec_t FAILS [23] = '{
    '{3'd0, 1'b1, 6'd5,  3'd2, 8'h01},
    '{3'd1, 1'b1, 6'd3,  3'd1, 8'hFF},
    '{3'd2, 1'b0, 6'd1,  3'd0, 8'h01},
    '{3'd2, 1'b0, 6'd2,  3'd0, 8'h01},
    '{3'd2, 1'b1, 6'd3,  3'd0, 8'h01},
    '{3'd3, 1'b0, 6'd1,  3'd0, 8'h01},
    '{3'd3, 1'b0, 6'd2,  3'd0, 8'h01},
    '{3'd3, 1'b0, 6'd3,  3'd0, 8'h01},
    '{3'd3, 1'b0, 6'd4,  3'd1, 8'h01},
    '{3'd3, 1'b0, 6'd5,  3'd1, 8'h01},
    '{3'd3, 1'b1, 6'd6,  3'd2, 8'h01},
    '{3'd4, 1'b0, 6'd1,  3'd0, 8'h01},
    '{3'd4, 1'b0, 6'd2,  3'd1, 8'h01},
    '{3'd4, 1'b0, 6'd3,  3'd2, 8'h01},
    '{3'd4, 1'b0, 6'd4,  3'd3, 8'h01},
    '{3'd4, 1'b1, 6'd5,  3'd4, 8'h01},
    '{3'd5, 1'b0, 6'd7,  3'd0, 8'h03},
    '{3'd5, 1'b0, 6'd8,  3'd0, 8'h03},
    '{3'd5, 1'b0, 6'd9,  3'd0, 8'h03},
    '{3'd5, 1'b0, 6'd10, 3'd3, 8'h01},
    '{3'd5, 1'b1, 6'd11, 3'd5, 8'h01},
    '{3'd6, 1'b0, 6'd4,  3'd0, 8'h20},
    '{3'd6, 1'b1, 6'd4,  3'd3, 8'hFF}
  };

  localparam expect_t EXPS [7] = '{
    '{1'b1, 3'd0, 6'd5,  6'd0,  2'b01, 6'd0, 6'd0,  2'b00},
    '{1'b1, 3'd0, 6'd3,  6'd0,  2'b01, 6'd0, 6'd0,  2'b00},
    '{1'b1, 3'd0, 6'd1,  6'd2,  2'b11, 6'd0, 6'd0,  2'b01},
    '{1'b1, 3'd2, 6'd4,  6'd5,  2'b11, 6'd0, 6'd16, 2'b11},
    '{1'b0, 3'd0, 6'd0,  6'd0,  2'b00, 6'd0, 6'd0,  2'b00},
    '{1'b1, 3'd5, 6'd10, 6'd11, 2'b11, 6'd0, 6'd1,  2'b11},
    '{1'b1, 3'd0, 6'd4,  6'd0,  2'b01, 6'd0, 6'd0,  2'b00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    startIn = 1'b0; failValid = 1'b0; testDone = 1'b0;
    failRow = '0; failCol = '0; failMask = '0;
  endtask

  task automatic doStart();
    @(negedge clk);
    idleInputs();
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
  endtask

  task automatic driveFail(input logic [5:0] r, input logic [2:0] c, input logic [7:0] m);
    failValid = 1'b1; failRow = r; failCol = c; failMask = m;
    @(negedge clk);
    failValid = 1'b0;
  endtask

  task automatic doDone();
    testDone = 1'b1;
    @(negedge clk);
    testDone = 1'b0;
  endtask

  task automatic chkResult(input string tag, input expect_t e);
    chk({tag, " R7 resultValid"}, 32'(resultValid), 32'd1);
    chk({tag, " R7 repairable"}, 32'(repairable), 32'(e.rep));
    chk({tag, " R2 bestLane"}, 32'(bestLane), 32'(e.lane));
    chk({tag, " R4 row0"}, 32'(repRow[0]), 32'(e.r0));
    chk({tag, " R4 row1"}, 32'(repRow[1]), 32'(e.r1));
    chk({tag, " R5 rowValid"}, 32'(repRowValid), 32'(e.rv));
    chk({tag, " R3 col0"}, 32'(repCol[0]), 32'(e.c0));
    chk({tag, " R3 col1"}, 32'(repCol[1]), 32'(e.c1));
    chk({tag, " R6 colValid"}, 32'(repColValid), 32'(e.cv));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idleInputs();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("reset R1 resultValid", 32'(resultValid), 32'd0);
    chk("reset R1 repairable", 32'(repairable), 32'd0);

    // R9: idle, no start yet: failure and done ignored
    failValid = 1'b1; failRow = 6'd9; failMask = 8'hFF; testDone = 1'b1;
    @(negedge clk);
    idleInputs();
    @(negedge clk);
    chk("idle R9 resultValid", 32'(resultValid), 32'd0);

    // Table walk: each scenario back to back failures then done
    for (int i = 0; i < 23; i++) begin
      if (i == 0 || FAILS[i].scen != FAILS[i-1].scen) doStart();
      driveFail(FAILS[i].row, FAILS[i].col, FAILS[i].mask);
      if (FAILS[i].last) begin
        doDone();
        chkResult($sformatf("scenario%0d", FAILS[i].scen), EXPS[FAILS[i].scen]);
      end
    end

    // R8: four diagonal failures are repairable
    doStart();
    for (int k = 0; k < 4; k++) driveFail(6'(k + 1), 3'(k), 8'h01);
    doDone();
    chkResult("diag4", '{1'b1, 3'd0, 6'd1, 6'd2, 2'b11, 6'd16, 6'd24, 2'b11});

    // R8: fifth diagonal failure in the done cycle flips the verdict
    doStart();
    for (int k = 0; k < 4; k++) driveFail(6'(k + 1), 3'(k), 8'h01);
    failValid = 1'b1; failRow = 6'd5; failCol = 3'd4; failMask = 8'h01; testDone = 1'b1;
    @(negedge clk);
    idleInputs();
    chk("done-cycle fail R8 repairable", 32'(repairable), 32'd0);
    chk("done-cycle fail R8 resultValid", 32'(resultValid), 32'd1);

    // R9: failure in the start cycle is dropped
    @(negedge clk);
    startIn = 1'b1; failValid = 1'b1; failRow = 6'd1; failCol = 3'd0; failMask = 8'h01;
    @(negedge clk);
    idleInputs();
    chk("start cycle R1 resultValid", 32'(resultValid), 32'd0);
    doDone();
    chk("start-cycle fail R9 repairable", 32'(repairable), 32'd1);
    chk("start-cycle fail R9 rowValid", 32'(repRowValid), 32'd0);
    chk("start-cycle fail R9 colValid", 32'(repColValid), 32'd0);

    // R9: failure after the result is reported is ignored
    driveFail(6'd9, 3'd1, 8'hFF);
    @(negedge clk);
    chk("post-done R9 resultValid", 32'(resultValid), 32'd1);
    chk("post-done R9 rowValid", 32'(repRowValid), 32'd0);
    chk("post-done R9 colValid", 32'(repColValid), 32'd0);

    // R1: start clears a reported result
    doStart();
    chk("restart R1 resultValid", 32'(resultValid), 32'd0);
    chk("restart R1 repairable", 32'(repairable), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule